// File: doc/BRIEF.md
# Dead-Time Phase Splitter

This block turns one reference square wave into two complementary output phases that are never high together. Phase 1 follows the high level of the reference and phase 2 follows its low level. Each phase rises only after a programmable guard interval that starts at the matching reference edge. Each phase drops in the cycle after the edge that ends its level. If a reference level ends before its guard interval has run out, that phase gives no pulse for that level.

An emergency kill input forces both phases low. How long they stay low depends on a 2-bit kill mode: only while kill is high, until the next reference edge, or until the block is disabled. The interrupt output follows phase 1 exactly, including its kill behaviour.

A period of zero is not a valid setting. With a zero period the block holds both phases low and raises a configuration-error flag. Disabling the block clears all of its state. Enabling it starts a guard interval, just as a reference edge does.

Top module: `deadband_gen`

## Requirements
- R1: While enabled with `period` equal to 0, `ph1` and `ph2` are low and `cfg_err` is high. `cfg_err` is low whenever `period` is nonzero or `en` is low.
- R2: A rising reference level sampled at clock edge k makes `ph1` high after edge k+period+1, provided the reference stays high and nothing else blocks it. `ph1` is low after the first clock edge that samples the reference low.
- R3: A falling reference level sampled at clock edge k makes `ph2` high after edge k+period+1, on the same conditions. `ph2` is low after the first clock edge that samples the reference high.
- R4: A reference high or low level lasting period+1 clock cycles or fewer produces no pulse on its phase.
- R5: `ph1` and `ph2` are never high in the same cycle.
- R6: `irq` equals `ph1` in every cycle.
- R7: With `kill_mode` 2'b00 or 2'b11, both phases are low in any cycle in which `kill` is high, and they resume as soon as `kill` falls.
- R8: With `kill_mode` 2'b01, a sampled `kill` keeps both phases low until a clock edge samples a reference edge while `kill` is low. A normal guard interval then follows that edge.
- R9: With `kill_mode` 2'b10, a sampled `kill` keeps both phases low until `en` is sampled low.
- R10: While `en` is low, all outputs are low and the guard counter is cleared. The first enabled clock edge starts a guard interval for the current reference level.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| ref_in | input | 1 | Reference square wave |
| kill | input | 1 | Emergency output shutdown |
| kill_mode | input | 2 | 00/11 level, 01 until reference edge, 10 until disable |
| period | input | PW | Guard interval setting; the interval lasts period+1 cycles |
| ph1 | output | 1 | Phase following the reference high level |
| ph2 | output | 1 | Phase following the reference low level |
| irq | output | 1 | Interrupt, copy of ph1 |
| cfg_err | output | 1 | Zero period while enabled |

## Verification
A wrong guard count shows up as a phase edge that is early or late by whole cycles, starting at the first reference edge after it goes wrong. A per-cycle comparison catches this within one guard interval. A kill latch that is stuck set or clears at the wrong time shows as phases that stay dark or come back too early. This appears on the next reference level whose guard interval completes. A stale sampled reference level shows as overlapping phases or a missing falling edge one cycle after the reference toggles.

// File: rtl/deadband_gen.sv
module deadband_gen #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ref_in,
  input  logic          kill,
  input  logic [1:0]    kill_mode,
  input  logic [PW-1:0] period,
  output logic          ph1,
  output logic          ph2,
  output logic          irq,
  output logic          cfg_err
);

  logic          ref_q, en_q, run, hold;
  logic [PW-1:0] cnt;
  logic          start, zero_p, latch_mode, gate, live;

  assign zero_p     = (period == '0);
  assign start      = en && (!en_q || (ref_in != ref_q));
  assign latch_mode = (kill_mode == 2'b01) || (kill_mode == 2'b10);
  assign gate       = kill || (latch_mode && hold);
  assign live       = en && en_q && !zero_p && !run && !gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      en_q  <= 1'b0;
      run   <= 1'b0;
      hold  <= 1'b0;
      cnt   <= '0;
    end else if (!en) begin
      ref_q <= ref_in;
      en_q  <= 1'b0;
      run   <= 1'b0;
      hold  <= 1'b0;
      cnt   <= '0;
    end else begin
      ref_q <= ref_in;
      en_q  <= 1'b1;
      if (start) begin
        cnt <= period;
        run <= 1'b1;
      end else if (run) begin
        if (cnt == '0) run <= 1'b0;
        else           cnt <= cnt - 1'b1;
      end
      case (kill_mode)
        2'b01:   if (kill) hold <= 1'b1; else if (start) hold <= 1'b0;
        2'b10:   if (kill) hold <= 1'b1;
        default: hold <= 1'b0;
      endcase
    end
  end

  assign ph1     = live && ref_q;
  assign ph2     = live && !ref_q;
  assign irq     = ph1;
  assign cfg_err = en && zero_p;

endmodule

module deadband_gen_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          ref_in,
  input logic          kill,
  input logic [1:0]    kill_mode,
  input logic [PW-1:0] period,
  input logic          ph1,
  input logic          ph2,
  input logic          irq,
  input logic          cfg_err
);

  p_zero_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && period == '0) |-> (!ph1 && !ph2 && cfg_err));

  p_ph1_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(ref_in)) |-> !ph1);

  p_ph2_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && $past(ref_in)) |-> !ph2);

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1 && ph2));

  p_kill_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> (!ph1 && !ph2 && !irq));

  p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!ph1 && !ph2 && !irq && !cfg_err));

endmodule

bind deadband_gen deadband_gen_chk #(.PW(PW)) chk_i (.*);

// File: tb/deadband_gen_tb.sv
module deadband_gen_tb_top;
  localparam int PW = 8;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ref_in = 1'b0, kill = 1'b0;
  logic [1:0] kill_mode = 2'b00;
  logic [PW-1:0] period = 8'd3;
  logic ph1, ph2, irq, cfg_err;

  int checks = 0, fails = 0;
  string req = "R11";

  int m_lvl = 0, m_since = 0, m_enp = 0, m_hold = 0;

  always #2 clk = ~clk;

  deadband_gen #(.PW(PW)) dut_i (.*);

  always @(posedge clk) begin
    if (!rst_n || !en) begin
      m_lvl = ref_in; m_since = 0; m_enp = 0; m_hold = 0;
    end else begin
      automatic bit st = (m_enp == 0) || (ref_in != m_lvl);
      if (st) m_since = 0; else m_since = m_since + 1;
      m_lvl = ref_in;
      m_enp = 1;
      if (kill_mode == 2'b01) begin
        if (kill) m_hold = 1; else if (st) m_hold = 0;
      end else if (kill_mode == 2'b10) begin
        if (kill) m_hold = 1;
      end else m_hold = 0;
    end
  end

  task automatic chk1(string r, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", r, nm, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit dark, ok, e1, e2;
    dark = kill || ((kill_mode == 2'b01 || kill_mode == 2'b10) && m_hold != 0);
    ok = rst_n && en && m_enp != 0 && period != 0 && !dark && (m_since >= int'(period) + 1);
    e1 = ok && m_lvl != 0;
    e2 = ok && m_lvl == 0;
    chk1(req, "ph1", ph1, e1);
    chk1(req, "ph2", ph2, e2);
    chk1("R6", "irq", irq, e1);
    chk1("R1", "cfg_err", cfg_err, rst_n && en && period == 0);
    chk1("R5", "overlap", ph1 & ph2, 1'b0);
  endtask

  always @(negedge clk) compare();

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulses(int hi, int lo, int reps);
    for (int i = 0; i < reps; i++) begin
      ref_in = 1'b1; step(hi);
      ref_in = 1'b0; step(lo);
    end
  endtask

  initial begin
    fork
      begin
        #1;
        step(3);
        req = "R11"; step(1);
        rst_n = 1'b1; step(2);
        req = "R10"; en = 1'b1; step(8);
        req = "R2"; pulses(12, 12, 3);
        req = "R3"; period = 8'd3; pulses(6, 15, 2);
        req = "R4"; pulses(2, 4, 3); pulses(4, 3, 2); pulses(5, 5, 2);
        req = "R10"; en = 1'b0; step(3); period = 8'd1; en = 1'b1; pulses(3, 3, 3); pulses(1, 2, 2);
        req = "R1"; en = 1'b0; period = 8'd0; step(1); en = 1'b1; pulses(4, 4, 2);
        en = 1'b0; period = 8'd5; step(1); en = 1'b1;
        req = "R7"; kill_mode = 2'b00; ref_in = 1'b1; step(10); kill = 1'b1; step(3); kill = 1'b0; step(4);
        kill_mode = 2'b11; kill = 1'b1; step(2); kill = 1'b0; step(3);
        req = "R8"; kill_mode = 2'b01; kill = 1'b1; step(1); kill = 1'b0; step(5);
        ref_in = 1'b0; step(12); ref_in = 1'b1; step(3); kill = 1'b1; step(1); ref_in = 1'b0; step(1); kill = 1'b0; step(10);
        ref_in = 1'b1; step(10);
        req = "R9"; kill_mode = 2'b10; kill = 1'b1; step(1); kill = 1'b0; pulses(10, 10, 2);
        en = 1'b0; step(2); en = 1'b1; pulses(10, 10, 2);
        req = "R2"; kill_mode = 2'b00;
        for (int i = 0; i < 300; i++) begin
          ref_in = ($urandom_range(0, 3) == 0) ? ~ref_in : ref_in;
          kill = ($urandom_range(0, 19) == 0);
          step(1);
        end
        kill = 1'b0; step(2);
      end
      begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule